// File: doc/BRIEF.md
# Accumulator Datapath with Operand and Load Selection

This block is the accumulator-centred datapath of a small load-store processor. It holds the single working register (the accumulator), an arithmetic/logic unit, and the negative, zero and carry status bits. The accumulator is always the ALU's first operand. A mux picks the second operand: either the shared data bus or a forced zero. A second mux picks what the accumulator captures: either the ALU result or the bus value itself. Every instruction leaves its result in the accumulator.

An external controller drives all the strobes. A load strobe commits the selected value on the next rising clock edge. A drive strobe presents the accumulator on a separate bus output with an enable, which is how a store puts data onto memory's data lines. The ALU either adds, with an optional inverted second operand and a selectable carry-in, or applies a per-bit function described by a 4-entry truth table.

Top module: `acc_datapath`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator becomes 0, N becomes 0, Z becomes 1 and C becomes 0. With `bus_drv` low, `bus_oe` is 0 and `bus_out` is 0.
- R2: At a rising edge with `acc_ld`=1 and `acc_from_alu`=0, the accumulator takes `bus_in`.
- R3: At a rising edge with `acc_ld`=1 and `acc_from_alu`=1, the accumulator takes the ALU result. The ALU's first operand is always the present accumulator value, and its second operand is `bus_in` unless R4 applies.
- R4: When `opb_zero`=1, the ALU's second operand is 0 instead of `bus_in`. A load of an AND result then clears the accumulator, and an add with carry-in 0 leaves it unchanged.
- R5: When `alu_arith`=1, the result is the low WIDTH bits of A + B' + cin, where B' is B inverted when `alu_sub`=1. The bit above them is the carry-out.
- R6: `cin_sel` picks the carry-in: 0 uses the stored C, 1 uses the inverse of C, 2 uses 0, and 3 uses 1.
- R7: When `alu_arith`=0, each result bit i equals `logic_tt[2*A[i]+B[i]]`. This gives AND with 4'b1000, OR with 4'b1110, XOR with 4'b0110 and NOT A with 4'b0011.
- R8: Every accumulator load sets N to the loaded value's top bit and sets Z to 1 exactly when the loaded value is 0.
- R9: With `acc_ld`=0, the accumulator, N, Z and C keep their values whatever the other inputs do.
- R10: `bus_oe` follows `bus_drv` in the same cycle. While `bus_drv`=1, `bus_out` shows the accumulator's present value, and it is 0 otherwise. When a drive and a load fall in one cycle, the bus shows the value held before the edge.
- R11: C takes the ALU carry-out only on loads with `acc_from_alu`=1 and `alu_arith`=1. Bus loads and logic-result loads leave C unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_ld | input | 1 | Load strobe for the accumulator and status bits |
| acc_from_alu | input | 1 | 1 = load the ALU result, 0 = load bus_in |
| opb_zero | input | 1 | 1 = ALU second operand is zero, 0 = bus_in |
| alu_arith | input | 1 | 1 = adder result, 0 = truth-table logic result |
| alu_sub | input | 1 | Invert the second operand in the adder |
| cin_sel | input | 2 | Carry-in source: 0 C, 1 not C, 2 zero, 3 one |
| logic_tt | input | 4 | Per-bit truth table indexed by {A bit, B bit} |
| bus_in | input | WIDTH | Value on the shared data bus |
| bus_drv | input | 1 | Drive strobe for the accumulator onto the bus |
| bus_out | output | WIDTH | Accumulator value for the bus, 0 when not driven |
| bus_oe | output | 1 | Bus output enable |
| acc_q | output | WIDTH | Accumulator contents |
| flag_n | output | 1 | Negative status bit |
| flag_z | output | 1 | Zero status bit |
| flag_c | output | 1 | Carry status bit |

## Verification
The overlap that matters is a store and an accumulator load in the same cycle. The bus must carry the value from before the edge, while the register takes the new value at that edge. The bench provokes this directly: it raises `bus_drv` together with `acc_ld` and a new bus value, and it does the same many times in a random phase. A behavioural model predicts the bus output from its own pre-edge accumulator and the registered state from the post-edge value, and every cycle is compared against it. A second overlap is carry-in chaining, where the carry stored by one add feeds the next add through `cin_sel`. Back-to-back adds with carry check it.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;
  localparam int TT_W = 4;

  typedef enum logic [1:0] {
    CIN_FLAG  = 2'd0,
    CIN_NFLAG = 2'd1,
    CIN_ZERO  = 2'd2,
    CIN_ONE   = 2'd3
  } cin_sel_e;
endpackage

// File: rtl/acc_dp_alu.sv
module acc_dp_alu
  import acc_dp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             arith,
  input  logic             sub,
  input  logic             cin,
  input  logic [TT_W-1:0]  tt,
  output logic [WIDTH-1:0] res,
  output logic             cout
);
  localparam int SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] opb_x;
  logic [SUM_W-1:0] sum;
  logic [WIDTH-1:0] lres;

  assign opb_x = sub ? ~opb : opb;
  assign sum   = {1'b0, opa} + {1'b0, opb_x} + {{WIDTH{1'b0}}, cin};

  // per-bit truth-table logic unit
  for (genvar i = 0; i < WIDTH; i++) begin : g_lu
    assign lres[i] = tt[{opa[i], opb[i]}];
  end

  assign res  = arith ? sum[WIDTH-1:0] : lres;
  assign cout = sum[WIDTH];

  // R7: the logic path ignores the carry-in entirely
  always_comb begin
    if (!arith && (tt == 4'b1000))
      a_and_r7: assert (res == (opa & opb));
  end
endmodule

// File: rtl/acc_dp_status.sv
module acc_dp_status #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd,
  input  logic             upd_c,
  input  logic [WIDTH-1:0] value,
  input  logic             c_new,
  output logic             n_q,
  output logic             z_q,
  output logic             c_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      n_q <= 1'b0;
      z_q <= 1'b1;
      c_q <= 1'b0;
    end else begin
      if (upd) begin
        n_q <= value[WIDTH-1];
        z_q <= (value == '0);
      end
      if (upd_c)
        c_q <= c_new;
    end
  end

  p_c_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !upd_c |=> $stable(c_q));
  p_nz_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !upd |=> ($stable(n_q) && $stable(z_q)));
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_dp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_ld,
  input  logic             acc_from_alu,
  input  logic             opb_zero,
  input  logic             alu_arith,
  input  logic             alu_sub,
  input  logic [1:0]       cin_sel,
  input  logic [3:0]       logic_tt,
  input  logic [WIDTH-1:0] bus_in,
  input  logic             bus_drv,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  output logic [WIDTH-1:0] acc_q,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  cin_sel_e         cin_mode;
  logic             cin;
  logic [WIDTH-1:0] opb;
  logic [WIDTH-1:0] alu_res;
  logic             alu_cout;
  logic [WIDTH-1:0] acc_d;
  logic             c_upd;

  assign cin_mode = cin_sel_e'(cin_sel);

  always_comb begin
    unique case (cin_mode)
      CIN_FLAG:  cin = flag_c;
      CIN_NFLAG: cin = ~flag_c;
      CIN_ZERO:  cin = 1'b0;
      default:   cin = 1'b1;
    endcase
  end

  assign opb = opb_zero ? ZERO : bus_in;

  acc_dp_alu #(.WIDTH(WIDTH)) u_alu (
    .opa   (acc_q),
    .opb   (opb),
    .arith (alu_arith),
    .sub   (alu_sub),
    .cin   (cin),
    .tt    (logic_tt),
    .res   (alu_res),
    .cout  (alu_cout)
  );

  assign acc_d = acc_from_alu ? alu_res : bus_in;

  always_ff @(posedge clk) begin
    if (rst)
      acc_q <= '0;
    else if (acc_ld)
      acc_q <= acc_d;
  end

  assign c_upd = acc_ld & acc_from_alu & alu_arith;

  acc_dp_status #(.WIDTH(WIDTH)) u_status (
    .clk   (clk),
    .rst   (rst),
    .upd   (acc_ld),
    .upd_c (c_upd),
    .value (acc_d),
    .c_new (alu_cout),
    .n_q   (flag_n),
    .z_q   (flag_z),
    .c_q   (flag_c)
  );

  assign bus_oe  = bus_drv;
  assign bus_out = bus_drv ? acc_q : ZERO;

  p_bus_load_r2: assert property (@(posedge clk) disable iff (rst)
    (acc_ld && !acc_from_alu) |=> (acc_q == $past(bus_in)));
  p_zero_add_r4: assert property (@(posedge clk) disable iff (rst)
    (acc_ld && acc_from_alu && opb_zero && alu_arith && !alu_sub && cin_sel == 2'd2)
      |=> (acc_q == $past(acc_q)));
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !acc_ld |=> $stable(acc_q));
  p_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_z == (acc_q == ZERO)) && (flag_n == acc_q[WIDTH-1]));
  p_drive_r10: assert property (@(posedge clk) disable iff (rst)
    bus_drv |-> (bus_oe && bus_out == acc_q));
  p_bus_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_drv |-> (!bus_oe && bus_out == ZERO));
endmodule

// File: tb/acc_datapath_test.sv
module acc_datapath_test;
  localparam int W = 8;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst;
  logic acc_ld, acc_from_alu, opb_zero, alu_arith, alu_sub, bus_drv;
  logic [1:0] cin_sel;
  logic [3:0] logic_tt;
  logic [W-1:0] bus_in, bus_out, acc_q;
  logic bus_oe, flag_n, flag_z, flag_c;

  int total = 0;
  int bad = 0;

  // reference state
  int m_acc, m_n, m_z, m_c;

  always #4 clk = ~clk;

  acc_datapath #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .acc_ld(acc_ld), .acc_from_alu(acc_from_alu),
    .opb_zero(opb_zero), .alu_arith(alu_arith), .alu_sub(alu_sub),
    .cin_sel(cin_sel), .logic_tt(logic_tt), .bus_in(bus_in), .bus_drv(bus_drv),
    .bus_out(bus_out), .bus_oe(bus_oe), .acc_q(acc_q),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(req, "acc", int'(acc_q), m_acc);
    chk(req, "N", int'(flag_n), m_n);
    chk(req, "Z", int'(flag_z), m_z);
    chk(req, "C", int'(flag_c), m_c);
  endtask

  // one controller cycle: set strobes, check bus before edge, advance model, check after
  task automatic cyc(input string req, input bit ld, input bit fa, input bit zb,
                     input bit ar, input bit sb, input int cs, input int tt,
                     input int bus, input bit drv);
    int b, bx, ci, s, r, co;
    acc_ld = ld; acc_from_alu = fa; opb_zero = zb; alu_arith = ar; alu_sub = sb;
    cin_sel = 2'(cs); logic_tt = 4'(tt); bus_in = W'(bus); bus_drv = drv;
    #1;
    chk("R10", "bus_oe", int'(bus_oe), int'(drv));
    chk("R10", "bus_out", int'(bus_out), drv ? m_acc : 0);
    b  = zb ? 0 : (bus & MASK);
    bx = sb ? (~b & MASK) : b;
    case (cs)
      0: ci = m_c;
      1: ci = 1 - m_c;
      2: ci = 0;
      default: ci = 1;
    endcase
    s  = m_acc + bx + ci;
    co = (s >> W) & 1;
    if (ar) r = s & MASK;
    else begin
      r = 0;
      for (int i = 0; i < W; i++) begin
        int idx;
        idx = 2 * ((m_acc >> i) & 1) + ((b >> i) & 1);
        if ((tt >> idx) & 1) r = r | (1 << i);
      end
    end
    if (!fa) r = bus & MASK;
    @(posedge clk);
    if (ld) begin
      m_acc = r;
      m_n = (r >> (W - 1)) & 1;
      m_z = (r == 0) ? 1 : 0;
      if (fa && ar) m_c = co;
    end
    @(negedge clk);
    chk_state(req);
  endtask

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    acc_ld = 0; acc_from_alu = 0; opb_zero = 0; alu_arith = 0; alu_sub = 0;
    cin_sel = 0; logic_tt = 0; bus_in = 8'hA5; bus_drv = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_acc = 0; m_n = 0; m_z = 1; m_c = 0;
    chk_state("R1");
    chk("R1", "bus_oe", int'(bus_oe), 0);
    chk("R1", "bus_out", int'(bus_out), 0);
    rst = 1'b0;

    // R2: load immediate from the bus
    cyc("R2", 1, 0, 0, 0, 0, 2, 0, 'h7F, 0);
    // R3/R5/R8: add 1 with carry-in 0 -> 0x80, N set
    cyc("R5", 1, 1, 0, 1, 0, 2, 0, 'h01, 0);
    chk("R8", "N after 0x80", int'(flag_n), 1);
    // R5: 0x80 + 0xFF -> 0x7F carry out
    cyc("R5", 1, 1, 0, 1, 0, 2, 0, 'hFF, 0);
    chk("R5", "carry", int'(flag_c), 1);
    // R6: add with carry using stored C
    cyc("R6", 1, 1, 0, 1, 0, 0, 0, 'h00, 0);
    chk("R6", "acc addc", int'(acc_q), 'h80);
    // R5: subtract 0x80 with carry-in 1 -> zero, no borrow
    cyc("R5", 1, 1, 0, 1, 1, 3, 0, 'h80, 0);
    chk("R8", "Z after sub", int'(flag_z), 1);
    // R6: inverted carry-in (C=1 -> cin 0)
    cyc("R6", 1, 1, 0, 1, 0, 1, 0, 'h05, 0);
    chk("R6", "acc inv-carry", int'(acc_q), 5);
    // R11: set C, then bus load and logic load keep it
    cyc("R11", 1, 1, 0, 1, 0, 3, 0, 'hFF, 0);
    cyc("R11", 1, 0, 0, 1, 0, 2, 0, 'hF3, 0);
    chk("R11", "C kept bus load", int'(flag_c), 1);
    // R7: AND, XOR, OR, NOT A
    cyc("R7", 1, 1, 0, 0, 0, 2, 'b1000, 'h0F, 0);
    chk("R7", "and", int'(acc_q), 'h03);
    chk("R11", "C kept logic", int'(flag_c), 1);
    cyc("R7", 1, 1, 0, 0, 0, 2, 'b0110, 'h5A, 0);
    cyc("R7", 1, 1, 0, 0, 0, 2, 'b1110, 'h80, 0);
    cyc("R7", 1, 1, 0, 0, 0, 2, 'b0011, 'h00, 0);
    // R4: add through zero operand keeps acc, AND with zero clears
    cyc("R4", 1, 1, 1, 1, 0, 2, 0, 'hFF, 0);
    cyc("R4", 1, 1, 1, 0, 0, 2, 'b1000, 'hFF, 0);
    chk("R4", "clear", int'(acc_q), 0);
    // R9: no load, busy inputs
    cyc("R2", 1, 0, 0, 0, 0, 2, 0, 'hC4, 0);
    cyc("R9", 0, 1, 0, 1, 1, 3, 'b1111, 'h33, 0);
    cyc("R9", 0, 0, 1, 0, 0, 1, 'b0000, 'h00, 0);
    chk("R9", "held", int'(acc_q), 'hC4);
    // R10: store, then store together with load
    cyc("R10", 0, 0, 0, 0, 0, 2, 0, 'h00, 1);
    cyc("R10", 1, 0, 0, 0, 0, 2, 0, 'h19, 1);
    chk("R10", "new acc after overlap", int'(acc_q), 'h19);
    cyc("R10", 0, 0, 0, 0, 0, 2, 0, 'h00, 1);

    // R3: random phase, model compared every cycle
    for (int k = 0; k < 400; k++) begin
      cyc("R3", 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          1'($urandom), int'($urandom % 4), int'($urandom % 16),
          int'($urandom % 256), 1'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule